// File: doc/BRIEF.md
# Branch Decision Unit

This unit decides, for one control-flow instruction per cycle, whether the flow of execution leaves the sequential path, and it produces the program counter that follows. The caller supplies the address of the instruction after the branch, a 4-bit branch kind, an 8-bit signed relative displacement, a 16-bit absolute destination and the current condition flags: negative (N), zero (Z), signed overflow (V) and carry (C).

Relative destinations are formed by sign-extending the displacement byte and adding it to the next-instruction address, with the sum wrapping at 16 bits. All conditional kinds use only the relative form. The one absolute kind takes the full 16-bit destination. The result is registered, so the decision and the new program counter appear one clock after the request. A cycle with no request leaves the program counter output where it was.

Top module: `branch_unit`

## Requirements
- R1: While reset (rst_n low) is held and on the first edge after it, valid_o = 0, taken_o = 0 and pc_o = 0x0000.
- R2: valid_o equals valid_i delayed by exactly one clock, and taken_o/pc_o in that cycle belong to the request sampled on the same edge.
- R3: A taken relative branch gives pc_o = (next_pc_i + sign-extended rel_off_i) mod 2^16. Displacements 0x00..0x7F go forward and 0x80..0xFF go backward, e.g. 0x0009+0x03 -> 0x000C and 0x000F+0xF7 -> 0x0006.
- R4: Kind 0 (relative always) is always taken.
- R5: Kind 1 (absolute jump) is always taken with pc_o = abs_tgt_i, and rel_off_i has no effect.
- R6: Kind 2 (carry clear) is taken when C = 0. Kind 3 (carry set) is taken when C = 1.
- R7: Kind 4 (equal) is taken when Z = 1. Kind 5 (not equal) is taken when Z = 0.
- R8: Kind 6 (minus) is taken when N = 1. Kind 7 (plus) is taken when N = 0.
- R9: Kind 8 (signed greater) is taken when Z = 0 and N = V. Kind 9 (signed less-or-equal) is taken when Z = 1 or N != V.
- R10: A request that is not taken gives pc_o = next_pc_i.
- R11: Kinds 10..15 are never taken.
- R12: A cycle with valid_i = 0 gives taken_o = 0 on the next edge and leaves pc_o unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| valid_i | input | 1 | A request is present this cycle |
| kind_i | input | 4 | Branch kind code (see requirements) |
| next_pc_i | input | 16 | Address of the instruction after the branch |
| rel_off_i | input | 8 | Signed relative displacement |
| abs_tgt_i | input | 16 | Absolute destination for kind 1 |
| flag_n_i | input | 1 | Negative flag |
| flag_z_i | input | 1 | Zero flag |
| flag_v_i | input | 1 | Signed overflow flag |
| flag_c_i | input | 1 | Carry flag |
| valid_o | output | 1 | Result present |
| taken_o | output | 1 | Branch taken |
| pc_o | output | 16 | Next program counter |

## Verification
Every result is due exactly one rising edge after its request is sampled. The bench drives inputs on the falling edge, and on the following falling edge it compares all three outputs with the model's prediction for that request. Idle cycles are predicted the same way: the model keeps the previous program counter and clears taken. Wrap-around and backward displacements, all sixteen flag combinations for every kind, and long mixed streams all go through this one-cycle comparison.

// File: rtl/branch_unit.sv
module branch_unit #(
  parameter int PC_W   = 16,
  parameter int OFF_W  = 8,
  parameter int KIND_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid_i,
  input  logic [KIND_W-1:0] kind_i,
  input  logic [PC_W-1:0]   next_pc_i,
  input  logic [OFF_W-1:0]  rel_off_i,
  input  logic [PC_W-1:0]   abs_tgt_i,
  input  logic              flag_n_i,
  input  logic              flag_z_i,
  input  logic              flag_v_i,
  input  logic              flag_c_i,
  output logic              valid_o,
  output logic              taken_o,
  output logic [PC_W-1:0]   pc_o
);
  localparam int EXT_W = PC_W - OFF_W;
  localparam logic [KIND_W-1:0] K_ALW = KIND_W'(0);
  localparam logic [KIND_W-1:0] K_ABS = KIND_W'(1);
  localparam logic [KIND_W-1:0] K_CC  = KIND_W'(2);
  localparam logic [KIND_W-1:0] K_CS  = KIND_W'(3);
  localparam logic [KIND_W-1:0] K_EQ  = KIND_W'(4);
  localparam logic [KIND_W-1:0] K_NE  = KIND_W'(5);
  localparam logic [KIND_W-1:0] K_MI  = KIND_W'(6);
  localparam logic [KIND_W-1:0] K_PL  = KIND_W'(7);
  localparam logic [KIND_W-1:0] K_GT  = KIND_W'(8);
  localparam logic [KIND_W-1:0] K_LE  = KIND_W'(9);

  logic [PC_W-1:0] rel_tgt;
  logic            sgn_lt;
  logic            cond;

  assign rel_tgt = next_pc_i + {{EXT_W{rel_off_i[OFF_W-1]}}, rel_off_i};
  assign sgn_lt  = flag_n_i ^ flag_v_i;

  always_comb begin
    case (kind_i)
      K_ALW, K_ABS: cond = 1'b1;
      K_CC:         cond = ~flag_c_i;
      K_CS:         cond = flag_c_i;
      K_EQ:         cond = flag_z_i;
      K_NE:         cond = ~flag_z_i;
      K_MI:         cond = flag_n_i;
      K_PL:         cond = ~flag_n_i;
      K_GT:         cond = ~flag_z_i & ~sgn_lt;
      K_LE:         cond = flag_z_i | sgn_lt;
      default:      cond = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      taken_o <= 1'b0;
      pc_o    <= '0;
    end else begin
      valid_o <= valid_i;
      taken_o <= valid_i & cond;
      if (valid_i)
        pc_o <= !cond ? next_pc_i : (kind_i == K_ABS) ? abs_tgt_i : rel_tgt;
    end
  end

  // R2
  taken_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    taken_o |-> valid_o);
  // R2
  valid_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i |=> valid_o);
  // R5
  abs_jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && kind_i == K_ABS) |=> (taken_o && pc_o == $past(abs_tgt_i)));
  // R4
  rel_always_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && kind_i == K_ALW) |=> taken_o);
  // R7
  equal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && kind_i == K_EQ) |=> (taken_o == $past(flag_z_i)));
  // R6
  carry_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && kind_i == K_CS) |=> (taken_o == $past(flag_c_i)));
  // R8
  minus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && kind_i == K_MI) |=> (taken_o == $past(flag_n_i)));
  // R10
  fallthrough_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i |=> (taken_o || pc_o == $past(next_pc_i)));
  // R11
  reserved_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && kind_i > K_LE) |=> !taken_o);
  // R12
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> (!taken_o && !valid_o && $stable(pc_o)));
endmodule

// File: tb/branch_unit_bench.sv
module branch_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic [3:0]  kind_i = '0;
  logic [15:0] next_pc_i = '0;
  logic [7:0]  rel_off_i = '0;
  logic [15:0] abs_tgt_i = '0;
  logic        flag_n_i = 1'b0, flag_z_i = 1'b0, flag_v_i = 1'b0, flag_c_i = 1'b0;
  logic        valid_o, taken_o;
  logic [15:0] pc_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  bit          e_valid = 1'b0;
  bit          e_taken = 1'b0;
  int          e_pc    = 0;
  string       e_tag   = "R1";

  always #5 clk = ~clk;

  branch_unit u_branch_unit (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .kind_i(kind_i),
    .next_pc_i(next_pc_i), .rel_off_i(rel_off_i), .abs_tgt_i(abs_tgt_i),
    .flag_n_i(flag_n_i), .flag_z_i(flag_z_i), .flag_v_i(flag_v_i), .flag_c_i(flag_c_i),
    .valid_o(valid_o), .taken_o(taken_o), .pc_o(pc_o)
  );

  function automatic bit model_cond(int k, bit n, bit z, bit v, bit c);
    case (k)
      0, 1: return 1'b1;
      2: return !c;
      3: return c;
      4: return z;
      5: return !z;
      6: return n;
      7: return !n;
      8: return !z && (n == v);
      9: return z || (n != v);
      default: return 1'b0;
    endcase
  endfunction

  function automatic string kind_tag(int k);
    case (k)
      0: return "R4";
      1: return "R5";
      2, 3: return "R6";
      4, 5: return "R7";
      6, 7: return "R8";
      8, 9: return "R9";
      default: return "R11";
    endcase
  endfunction

  task automatic compare();
    checks++;
    if (valid_o !== e_valid || taken_o !== e_taken || pc_o !== 16'(e_pc)) begin
      fails++;
      $display("FAIL %s: got valid=%b taken=%b pc=%h, expected valid=%b taken=%b pc=%h",
               e_tag, valid_o, taken_o, pc_o, e_valid, e_taken, 16'(e_pc));
    end
  endtask

  // Compare the previous prediction, then drive one cycle and predict it.
  task automatic step(bit v, int k, int nxt, int off, int abs_t, bit n, bit z, bit ov, bit c);
    int tgt;
    bit t;
    @(negedge clk);
    compare();
    valid_i = v; kind_i = 4'(k); next_pc_i = 16'(nxt); rel_off_i = 8'(off);
    abs_tgt_i = 16'(abs_t); flag_n_i = n; flag_z_i = z; flag_v_i = ov; flag_c_i = c;
    e_valid = v;
    if (!v) begin
      e_taken = 1'b0;
      e_tag = "R12";
    end else begin
      t = model_cond(k, n, z, ov, c);
      e_taken = t;
      if (!t) begin
        e_pc = nxt & 16'hFFFF;
        e_tag = (k > 9) ? "R11" : "R10";
      end else if (k == 1) begin
        e_pc = abs_t & 16'hFFFF;
        e_tag = "R5";
      end else begin
        tgt = nxt + ((off >= 128) ? off - 256 : off);
        e_pc = tgt & 16'hFFFF;
        e_tag = (k == 0) ? "R3/R4" : {"R3/", kind_tag(k)};
      end
      if (t && k != 0 && k != 1) e_tag = {"R3/", kind_tag(k)};
    end
  endtask

  initial begin
    // R1: reset state
    repeat (2) @(negedge clk);
    compare();
    rst_n = 1'b1;
    // R3: the two worked examples and both wrap directions
    step(1, 0, 'h0009, 'h03, 0, 0, 0, 0, 0);
    step(1, 0, 'h000F, 'hF7, 0, 0, 0, 0, 0);
    step(1, 0, 'hFFF0, 'h20, 0, 0, 0, 0, 0);
    step(1, 0, 'h0005, 'h80, 0, 0, 0, 0, 0);
    step(1, 0, 'h1234, 'h7F, 0, 0, 0, 0, 0);
    // R5: absolute jump ignores displacement
    step(1, 1, 'h4000, 'hFF, 'hBEEF, 0, 0, 0, 0);
    step(1, 1, 'h4000, 'h01, 'h0000, 1, 1, 1, 1);
    // R12: idle cycles hold pc_o
    step(0, 0, 'h7777, 'h11, 'h2222, 0, 0, 0, 0);
    step(0, 1, 'h1111, 'h11, 'h3333, 0, 0, 0, 0);
    // R6-R11: every kind against every flag combination
    for (int k = 0; k < 16; k++)
      for (int f = 0; f < 16; f++)
        step(1, k, 'h8000 + k * 16 + f, 'hF0 + f, 'h0100 * f, f[3], f[2], f[1], f[0]);
    // R2: mixed stream with gaps
    for (int i = 0; i < 400; i++)
      step(($urandom % 4) != 0, $urandom % 16, $urandom % 65536, $urandom % 256,
           $urandom % 65536, $urandom % 2, $urandom % 2, $urandom % 2, $urandom % 2);
    @(negedge clk);
    compare();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule